// File: doc/BRIEF.md
# Domain and Access Permission Checker

This block sits beside the translation lookaside buffer of a memory management unit in the style of classic 32-bit application cores. Each request brings the access kind, the privilege state, the virtual address with its alignment mask, and the current control bits. A hit request also brings the fields of the matching translation entry. From these the block decides whether the access may proceed. If it may not, the block classifies the fault.

A one-cycle result follows each request. The result gives a fault flag and a fault class (alignment, domain or permission). It says whether the abort is a prefetch abort or a data abort. It gives the level of the faulting entry (section or page), the domain and write flag that a data abort reports, and an unpredictable-encoding flag. When translation is off, the block also marks the access as a flat passthrough and says whether it is uncacheable. The entry store and the table walk live elsewhere.

Top module: `mmu_access_guard`

## Requirements
- R1: Access kind encoding is 0 read, 1 write, 2 fetch; 3 behaves as a read. For a non-fetch access, an alignment fault (class 1) is raised when (strict-alignment bit set or unaligned not allowed) and the low address bits ANDed with the request mask are nonzero. Fetches never raise it.
- R2: With translation off, `bypass` is 1 and no domain or permission fault is raised. `uncacheable` is 1 when the remap-enable bit is 0, or when the type-0 inner or outer field is 0 or the type-0 memory type is not 2. With translation on, both flags are 0.
- R3: The domain code used is the 2-bit field at bits [2d+1:2d] of the domain control word, where d is the entry's domain number.
- R4: Domain code 0 raises a domain fault (class 2). Code 3 passes with no permission check. Code 1 proceeds to the permission check. Code 2 raises no fault and sets `unpredictable`.
- R5: When the access-flag-enable bit is set, bit 0 of the entry's 3-bit permission code is forced to 1 before decoding.
- R6: Permission code 0 with the extended-permission bit set always aborts. With it clear, the 2-bit legacy protection field decides: value 2 aborts writes, value 1 aborts writes or unprivileged accesses, and 0 or 3 abort always.
- R7: Code 1 aborts unprivileged accesses. Code 2 aborts unprivileged writes. Code 3 never aborts. Code 5 aborts unprivileged accesses or writes. Codes 6 and 7 abort writes. Code 4 raises no fault and sets `unpredictable`. Aborts here are class 3.
- R8: A fetch with the entry's execute-never bit set faults with class 3 when the permission check is reached. Every fault on a fetch sets `prefetch_abort`. A data abort reports `fault_write` equal to the write kind, and `fault_domain` equal to the entry's domain for domain and permission faults (0 for alignment).
- R9: `fault_section` equals the entry's section flag for domain and permission faults and is 0 for alignment faults.
- R10: An access is privileged only when the core is not in user mode and the request is not marked as forced-user.
- R11: Fault class encoding is 0 none, 1 alignment, 2 domain, 3 permission. Alignment outranks domain, and domain outranks permission. `fault` is 1 exactly when the class is nonzero.
- R12: The result appears with `rsp_valid` in the cycle after `req_valid`. When `rsp_valid` is 0, and during reset, all result outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Request present this cycle |
| acc_kind | input | 2 | 0 read, 1 write, 2 fetch |
| user_mode | input | 1 | Core is in user mode |
| force_user | input | 1 | Request checked as unprivileged |
| vaddr | input | VA_W | Virtual address |
| align_mask | input | AM_W | Alignment mask on low address bits |
| allow_unaligned | input | 1 | Request tolerates misalignment |
| ctl_strict_align | input | 1 | Strict alignment checking |
| ctl_mmu_on | input | 1 | Translation enabled |
| ctl_afe | input | 1 | Access-flag enable |
| ctl_xperm | input | 1 | Extended permission model |
| ctl_prot | input | 2 | Legacy protection field |
| ctl_remap | input | 1 | Remap enable |
| remap_inner0 | input | 2 | Inner attribute for type 0 |
| remap_outer0 | input | 2 | Outer attribute for type 0 |
| remap_type0 | input | 2 | Memory type for type 0 |
| dom_ctl | input | 2*2**DOM_W | Domain control word |
| ent_domain | input | DOM_W | Entry domain number |
| ent_perm | input | 3 | Entry permission code |
| ent_xn | input | 1 | Entry execute-never |
| ent_section | input | 1 | Entry is a section (1) or page (0) |
| rsp_valid | output | 1 | Result valid |
| fault | output | 1 | Access faults |
| fault_class | output | 2 | 0 none, 1 alignment, 2 domain, 3 permission |
| prefetch_abort | output | 1 | Fault is a prefetch abort |
| fault_section | output | 1 | Faulting entry level |
| fault_domain | output | DOM_W | Domain reported on data abort |
| fault_write | output | 1 | Write flag reported on data abort |
| bypass | output | 1 | Flat passthrough, translation off |
| uncacheable | output | 1 | Passthrough access is uncacheable |
| unpredictable | output | 1 | Unpredictable domain or permission code |

## Verification
Any wrong decision by the block shows up as a wrong fault class or attribute flag on the very next cycle after the request, because there is no state beyond the single result register. A wrong domain-field select, a lost override bit or a wrong priority therefore shows up on the first request that reaches that branch. Random requests are biased so that every domain code, every permission code and every value of the legacy protection field is reached many times. Directed cases cover the priority corners and the unpredictable encodings.

// File: rtl/mmu_access_guard.sv
module mmu_access_guard #(
  parameter int VA_W  = 32,
  parameter int AM_W  = 3,
  parameter int DOM_W = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        req_valid,
  input  logic [1:0]                  acc_kind,
  input  logic                        user_mode,
  input  logic                        force_user,
  input  logic [VA_W-1:0]             vaddr,
  input  logic [AM_W-1:0]             align_mask,
  input  logic                        allow_unaligned,
  input  logic                        ctl_strict_align,
  input  logic                        ctl_mmu_on,
  input  logic                        ctl_afe,
  input  logic                        ctl_xperm,
  input  logic [1:0]                  ctl_prot,
  input  logic                        ctl_remap,
  input  logic [1:0]                  remap_inner0,
  input  logic [1:0]                  remap_outer0,
  input  logic [1:0]                  remap_type0,
  input  logic [2*(2**DOM_W)-1:0]     dom_ctl,
  input  logic [DOM_W-1:0]            ent_domain,
  input  logic [2:0]                  ent_perm,
  input  logic                        ent_xn,
  input  logic                        ent_section,
  output logic                        rsp_valid,
  output logic                        fault,
  output logic [1:0]                  fault_class,
  output logic                        prefetch_abort,
  output logic                        fault_section,
  output logic [DOM_W-1:0]            fault_domain,
  output logic                        fault_write,
  output logic                        bypass,
  output logic                        uncacheable,
  output logic                        unpredictable
);
  localparam logic [1:0] K_WRITE = 2'd1;
  localparam logic [1:0] K_FETCH = 2'd2;
  localparam logic [1:0] C_NONE = 2'd0, C_ALIGN = 2'd1, C_DOM = 2'd2, C_PERM = 2'd3;

  logic is_fetch, is_write, priv, misaligned;
  logic [1:0] dom_code;
  logic [2:0] perm_eff;
  logic perm_abort, perm_unpred;
  logic [1:0] cls;
  logic unc_c, unpred_c;

  assign is_fetch   = (acc_kind == K_FETCH);
  assign is_write   = (acc_kind == K_WRITE);
  assign priv       = !user_mode && !force_user;
  assign misaligned = !is_fetch && (ctl_strict_align || !allow_unaligned)
                      && |(vaddr[AM_W-1:0] & align_mask);
  assign dom_code   = dom_ctl[2*ent_domain +: 2];
  assign perm_eff   = ent_perm | {2'b00, ctl_afe};

  always_comb begin
    perm_abort  = 1'b0;
    perm_unpred = 1'b0;
    case (perm_eff)
      3'd0: begin
        if (ctl_xperm) perm_abort = 1'b1;
        else case (ctl_prot)
          2'd2:    perm_abort = is_write;
          2'd1:    perm_abort = is_write || !priv;
          default: perm_abort = 1'b1;
        endcase
      end
      3'd1: perm_abort = !priv;
      3'd2: perm_abort = !priv && is_write;
      3'd3: perm_abort = 1'b0;
      3'd4: perm_unpred = 1'b1;
      3'd5: perm_abort = !priv || is_write;
      default: perm_abort = is_write;
    endcase
  end

  always_comb begin
    cls      = C_NONE;
    unpred_c = 1'b0;
    if (misaligned) cls = C_ALIGN;
    else if (ctl_mmu_on) begin
      case (dom_code)
        2'd0: cls = C_DOM;
        2'd1: begin
          if (perm_abort || (is_fetch && ent_xn)) cls = C_PERM;
          unpred_c = perm_unpred;
        end
        2'd2: unpred_c = 1'b1;
        default: cls = C_NONE;
      endcase
    end
  end

  assign unc_c = !ctl_mmu_on && (!ctl_remap || remap_inner0 == 2'd0 ||
                 remap_outer0 == 2'd0 || remap_type0 != 2'd2);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid      <= 1'b0;
      fault          <= 1'b0;
      fault_class    <= C_NONE;
      prefetch_abort <= 1'b0;
      fault_section  <= 1'b0;
      fault_domain   <= '0;
      fault_write    <= 1'b0;
      bypass         <= 1'b0;
      uncacheable    <= 1'b0;
      unpredictable  <= 1'b0;
    end else begin
      rsp_valid      <= req_valid;
      fault          <= req_valid && (cls != C_NONE);
      fault_class    <= req_valid ? cls : C_NONE;
      prefetch_abort <= req_valid && (cls != C_NONE) && is_fetch;
      fault_section  <= req_valid && (cls == C_DOM || cls == C_PERM) && ent_section;
      fault_domain   <= (req_valid && !is_fetch && (cls == C_DOM || cls == C_PERM))
                        ? ent_domain : '0;
      fault_write    <= req_valid && (cls != C_NONE) && !is_fetch && is_write;
      bypass         <= req_valid && !ctl_mmu_on;
      uncacheable    <= req_valid && unc_c;
      unpredictable  <= req_valid && unpred_c;
    end
  end

  AST_FETCH_NO_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
    $past(req_valid && acc_kind == K_FETCH) |-> fault_class != C_ALIGN); // R1
  AST_OFF_NO_XLAT_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    $past(req_valid && !ctl_mmu_on) |-> (fault_class == C_NONE || fault_class == C_ALIGN)); // R2
  AST_MANAGER_PASSES: assert property (@(posedge clk) disable iff (!rst_n)
    $past(req_valid && ctl_mmu_on && dom_code == 2'd3 && !misaligned) |-> !fault); // R4
  AST_PREFETCH_ON_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
    prefetch_abort |-> $past(acc_kind == K_FETCH) && fault); // R8
  AST_FAULT_MATCHES_CLASS: assert property (@(posedge clk) disable iff (!rst_n)
    fault == (fault_class != C_NONE)); // R11
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> !fault && !bypass && !uncacheable && !unpredictable); // R12
  AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid == $past(req_valid)); // R12
endmodule

// File: tb/sim_mmu_access_guard.sv
module sim_mmu_access_guard;
  localparam int VA_W = 32, AM_W = 3, DOM_W = 4;
  localparam int DC_W = 2*(2**DOM_W);

  logic clk = 0, rst_n = 0, req_valid = 0;
  logic [1:0] acc_kind = 0;
  logic user_mode = 0, force_user = 0;
  logic [VA_W-1:0] vaddr = 0;
  logic [AM_W-1:0] align_mask = 0;
  logic allow_unaligned = 0, ctl_strict_align = 0, ctl_mmu_on = 0, ctl_afe = 0, ctl_xperm = 0;
  logic [1:0] ctl_prot = 0;
  logic ctl_remap = 0;
  logic [1:0] remap_inner0 = 0, remap_outer0 = 0, remap_type0 = 0;
  logic [DC_W-1:0] dom_ctl = 0;
  logic [DOM_W-1:0] ent_domain = 0;
  logic [2:0] ent_perm = 0;
  logic ent_xn = 0, ent_section = 0;
  logic rsp_valid, fault, prefetch_abort, fault_section, fault_write, bypass, uncacheable, unpredictable;
  logic [1:0] fault_class;
  logic [DOM_W-1:0] fault_domain;

  int checks = 0, fails = 0, cycles = 0;

  always #10 clk = ~clk;

  mmu_access_guard #(.VA_W(VA_W), .AM_W(AM_W), .DOM_W(DOM_W)) u0 (.*);

  // {fault, class, pabt, section, domain, write, bypass, unc, unpred}
  function automatic logic [12:0] model();
    logic f, w, pr, al, ab, un, uc;
    logic [1:0] c, d;
    logic [2:0] p;
    f  = (acc_kind == 2'd2);
    w  = (acc_kind == 2'd1);
    pr = !user_mode && !force_user;
    al = !f && (ctl_strict_align || !allow_unaligned) && ((vaddr[AM_W-1:0] & align_mask) != 0);
    c = 0; un = 0; ab = 0;
    d = dom_ctl[ent_domain*2 +: 2];
    p = ctl_afe ? (ent_perm | 3'd1) : ent_perm;
    case (p)
      0: ab = ctl_xperm ? 1'b1 : (ctl_prot == 2) ? w : (ctl_prot == 1) ? (w || !pr) : 1'b1;
      1: ab = !pr;
      2: ab = !pr && w;
      5: ab = !pr || w;
      6, 7: ab = w;
      default: ab = 0;
    endcase
    if (al) c = 1;
    else if (ctl_mmu_on) begin
      if (d == 0) c = 2;
      else if (d == 2) un = 1;
      else if (d == 1) begin
        if (ab || (f && ent_xn)) c = 3;
        if (p == 4) un = 1;
      end
    end
    uc = !ctl_mmu_on && (!ctl_remap || remap_inner0 == 0 || remap_outer0 == 0 || remap_type0 != 2);
    return {c != 0, c, (c != 0) && f, (c >= 2) && ent_section,
            ((c >= 2) && !f) ? ent_domain : 4'd0, (c != 0) && !f && w,
            !ctl_mmu_on, uc, un};
  endfunction

  function automatic logic [12:0] got();
    return {fault, fault_class, prefetch_abort, fault_section, fault_domain,
            fault_write, bypass, uncacheable, unpredictable};
  endfunction

  task automatic check(string tag, logic [12:0] act, logic [12:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %013b expected %013b", tag, act, exp);
    end
  endtask

  task automatic go(string tag);
    logic [12:0] e;
    e = model();
    req_valid = 1;
    @(negedge clk);
    check(tag, {got()}, e);
    checks++;
    if (rsp_valid !== 1'b1) begin
      fails++;
      $display("FAIL R12: rsp_valid got %b expected 1", rsp_valid);
    end
    req_valid = 0;
  endtask

  task automatic base();
    acc_kind = 0; user_mode = 0; force_user = 0; vaddr = 0; align_mask = 0;
    allow_unaligned = 1; ctl_strict_align = 0; ctl_mmu_on = 1; ctl_afe = 0;
    ctl_xperm = 0; ctl_prot = 0; ctl_remap = 0; remap_inner0 = 1; remap_outer0 = 1;
    remap_type0 = 2; dom_ctl = '0; ent_domain = 0; ent_perm = 3; ent_xn = 0; ent_section = 0;
  endtask

  initial begin
    while (cycles < 100000) begin @(posedge clk); cycles++; end
    fails++; checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    base();
    repeat (3) @(negedge clk);
    check("R12 reset", got(), 13'd0);
    rst_n = 1;
    @(negedge clk);
    check("R12 idle", got(), 13'd0);

    // R1 fetch exempt, read faults
    base(); ctl_strict_align = 1; vaddr = 32'h3; align_mask = 3'b011; acc_kind = 2; go("R1 fetch misaligned");
    check("R1 fetch no align", {14'd0, fault_class == 2'd1}, 15'd0);
    acc_kind = 0; go("R1 read misaligned");
    check("R1 class", {13'd0, fault_class}, 15'd1);
    base(); vaddr = 32'h2; align_mask = 3'b001; allow_unaligned = 0; acc_kind = 1; go("R1 aligned write ok");
    // R2
    base(); ctl_mmu_on = 0; go("R2 off uncacheable");
    check("R2 unc", {14'd0, uncacheable}, 15'd1);
    ctl_remap = 1; go("R2 off remap cacheable");
    check("R2 cacheable", {14'd0, uncacheable}, 15'd0);
    remap_type0 = 1; go("R2 remap type");
    // R3
    base(); dom_ctl = '0; dom_ctl[11:10] = 2'd3; ent_perm = 0; ent_domain = 5; go("R3 domain 5 manager");
    check("R3 pass", {14'd0, fault}, 15'd0);
    ent_domain = 4; ent_section = 1; go("R3 domain 4 no access");
    check("R9 section level", {14'd0, fault_section}, 15'd1);
    // R4
    base(); dom_ctl[1:0] = 2'd2; go("R4 domain 2");
    check("R4 unpred", {14'd0, unpredictable}, 15'd1);
    // R5
    base(); dom_ctl[1:0] = 1; ent_perm = 0; ctl_xperm = 1; ctl_afe = 1; acc_kind = 1; go("R5 afe priv write");
    check("R5 no fault", {14'd0, fault}, 15'd0);
    user_mode = 1; go("R5 afe user");
    // R6
    base(); dom_ctl[1:0] = 1; ent_perm = 0; ctl_prot = 2; go("R6 prot2 read");
    acc_kind = 1; go("R6 prot2 write");
    ctl_prot = 1; acc_kind = 0; user_mode = 1; go("R6 prot1 user read");
    ctl_prot = 3; user_mode = 0; go("R6 prot3");
    ctl_xperm = 1; ctl_prot = 2; go("R6 xperm");
    // R7
    base(); dom_ctl[1:0] = 1; ent_perm = 4; go("R7 perm4");
    ent_perm = 6; acc_kind = 1; go("R7 perm6 write");
    ent_perm = 2; user_mode = 1; go("R7 perm2 user write");
    // R8
    base(); dom_ctl[1:0] = 1; ent_xn = 1; acc_kind = 2; go("R8 fetch xn");
    check("R8 prefetch", {13'd0, prefetch_abort, fault_class == 2'd3}, 15'd3);
    acc_kind = 0; go("R8 read ignores xn");
    base(); dom_ctl[15:14] = 0; ent_domain = 7; acc_kind = 1; go("R8 data domain report");
    check("R8 domain field", {11'd0, fault_domain}, 15'd7);
    // R10
    base(); dom_ctl[1:0] = 1; ent_perm = 1; force_user = 1; go("R10 forced user");
    check("R10 aborts", {14'd0, fault}, 15'd1);
    // R11 priority
    base(); dom_ctl = '0; ctl_strict_align = 1; vaddr = 1; align_mask = 1; go("R11 align over domain");
    check("R11 class", {13'd0, fault_class}, 15'd1);
    @(negedge clk);
    check("R12 idle after", got(), 13'd0);

    for (int i = 0; i < 4000; i++) begin
      logic [12:0] e;
      acc_kind = 2'($urandom); user_mode = 1'($urandom); force_user = ($urandom % 4) == 0;
      vaddr = $urandom; align_mask = ($urandom % 3 == 0) ? 3'($urandom) : 3'd0;
      allow_unaligned = 1'($urandom); ctl_strict_align = ($urandom % 4) == 0;
      ctl_mmu_on = ($urandom % 5) != 0; ctl_afe = ($urandom % 4) == 0;
      ctl_xperm = 1'($urandom); ctl_prot = 2'($urandom); ctl_remap = 1'($urandom);
      remap_inner0 = 2'($urandom); remap_outer0 = 2'($urandom); remap_type0 = 2'($urandom);
      dom_ctl = {$urandom, $urandom}; ent_domain = 4'($urandom); ent_perm = 3'($urandom);
      ent_xn = 1'($urandom); ent_section = 1'($urandom);
      e = model();
      case (e[11:10])
        2'd1: go("R1 random");
        2'd2: go("R4 random");
        2'd3: go("R7 random");
        default: go("R11 random");
      endcase
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule